// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register set that software uses to drive an SMBus host controller. A small synchronous port with a 3-bit offset, a write strobe and a read strobe reaches a status register, a control register, the command byte, the slave address byte, two data bytes and a block-data window. The window is backed by a 32-byte buffer. The block does no bus signalling itself. It hands the selected protocol and the transfer bytes to an external transaction sequencer, and later takes back the sequencer's completion and error result.

To run a transfer, software loads the command, address and data registers. It then writes the control register with the start bit set and the protocol code in bits 4:2. Busy stays set until the sequencer reports done. At that point the error flags are captured and a completion flag is raised, which can also drive an interrupt request. Block transfers move through offset 7: a read of the control register rewinds the buffer index, and each later offset-7 access steps to the next byte. The sequencer has its own random-access port into the same buffer.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, every register reads 0x00 (status, control, command, address, data-0, data-1), `irq` is 0 and `seq_start` is 0.
- R2: Offsets 3 (command), 4 (slave address), 5 (data-0) and 6 (data-1) read back the last byte written while idle. Offsets 1 and 8-and-up do not exist, so offset 1 reads 0x00.
- R3: Writing control (offset 2) while idle with bit 6 set does three things: it sets status bit 0 (busy) and pulses `seq_start` high for exactly one cycle, starting one clock after the write. It also presents control bits 4:2 on `seq_proto` (000 quick, 001 byte, 010 byte-data, 011 word-data, 101 block-data). Control reads back bits 4:2 and bit 0 (interrupt enable), while bit 6 and all other bits read 0.
- R4: When `seq_done` is high while busy, busy clears and status bit 1 (done) sets. Status bits 2 (no response), 3 (collision) and 4 (failed) load `seq_nack`, `seq_collision` and `seq_failed`.
- R5: Writing status clears each of bits 1 to 4 whose written bit is 1 and leaves the others. The busy bit and bits 7:5 are not affected by writes.
- R6: While busy, writes to control, command, address, data-0, data-1 and block data are ignored. They do not start a second transfer and do not move the buffer index.
- R7: Any read of control rewinds the block-buffer index to 0.
- R8: Each offset-7 read returns the buffer byte at the index, and each idle offset-7 write stores to it. Either access then advances the index by one.
- R9: The index saturates at 31. Further offset-7 accesses read or overwrite byte 31.
- R10: `irq` is high exactly when control bit 0 is 1 and status bit 1 (done) is 1.
- R11: On completion with slave-address bit 0 = 1 (read direction), data-0 and data-1 load `seq_rdata0` and `seq_rdata1`. With bit 0 = 0 they keep their values.
- R12: The sequencer port reads the buffer byte at `seq_buf_addr` combinationally, and writes `seq_buf_wdata` there when `seq_buf_we` is high. The host sees those bytes through offset 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Completion interrupt request |
| seq_start | output | 1 | One-cycle transfer launch pulse |
| seq_proto | output | 3 | Selected protocol code |
| seq_slave | output | 8 | Slave address byte, direction in bit 0 |
| seq_cmd | output | 8 | Command byte |
| seq_data0 | output | 8 | Data-0 / block count |
| seq_data1 | output | 8 | Data-1 |
| seq_done | input | 1 | Transfer finished |
| seq_nack | input | 1 | No device responded |
| seq_collision | input | 1 | Bus collision |
| seq_failed | input | 1 | Transfer failed |
| seq_rdata0 | input | 8 | Received byte for data-0 |
| seq_rdata1 | input | 8 | Received byte for data-1 |
| seq_buf_addr | input | 5 | Sequencer buffer address |
| seq_buf_we | input | 1 | Sequencer buffer write enable |
| seq_buf_wdata | input | 8 | Sequencer buffer write data |
| seq_buf_rdata | output | 8 | Sequencer buffer read data |

## Verification
The bench runs 33 block writes and 33 block reads in a row. An index that wraps instead of saturating would return byte 0 where byte 31 is expected. It writes the busy bit and a single error bit as 1. A status register that cleared the wrong bits, or let busy be cleared, would read a wrong value, for example 0x10 where 0x12 is expected. It writes the command, control and block registers in mid-transfer. A design that accepted those writes would change the command byte, change the protocol bits or shift the buffer contents. It also completes transfers in both directions, so that data registers that loaded on a write-direction transfer would be caught.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam logic [2:0] OFS_STATUS = 3'd0;
    localparam logic [2:0] OFS_CTRL   = 3'd2;
    localparam logic [2:0] OFS_CMD    = 3'd3;
    localparam logic [2:0] OFS_SLAVE  = 3'd4;
    localparam logic [2:0] OFS_DATA0  = 3'd5;
    localparam logic [2:0] OFS_DATA1  = 3'd6;
    localparam logic [2:0] OFS_BLOCK  = 3'd7;

    localparam int CTL_START_BIT = 6;
    localparam int CTL_IEN_BIT   = 0;

    // error result reported by the sequencer; packed order matches status bits 4:2
    typedef struct packed {
        logic failed;
        logic collision;
        logic nack;
    } result_t;

    // status register image, bits 4:0
    typedef struct packed {
        result_t res;
        logic    done;
        logic    busy;
    } stat_t;

    typedef struct packed {
        logic [2:0] proto;
        logic       ien;
    } ctl_t;

    function automatic logic [7:0] status_byte(stat_t s);
        return {3'b000, s};
    endfunction

    function automatic logic [7:0] ctl_byte(ctl_t c);
        return {3'b000, c.proto, 1'b0, c.ien};
    endfunction

endpackage

// File: rtl/smbh_status.sv
module smbh_status
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_go,
    input  logic [4:1] clr_mask,
    input  logic       seq_done,
    input  result_t    seq_res,
    output stat_t      st
);

    logic finish;
    assign finish = st.busy && seq_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (start_go)
                st.busy <= 1'b1;
            else if (finish)
                st.busy <= 1'b0;

            if (finish) begin
                st.done <= 1'b1;
                st.res  <= seq_res;
            end else begin
                st.done <= st.done & ~clr_mask[1];
                st.res  <= st.res & ~result_t'(clr_mask[4:2]);
            end
        end
    end

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        start_go |=> st.busy);

    // R4
    done_clr_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> (!st.busy && st.done));

    // R4
    res_load_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> (st.res == $past(seq_res)));

    // R5
    w1c_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!finish && clr_mask[1]) |=> !st.done);

endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rewind,
    input  logic          host_adv,
    input  logic          host_we,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [IW-1:0] sq_addr,
    input  logic          sq_we,
    input  logic [DW-1:0] sq_wdata,
    output logic [DW-1:0] sq_rdata
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] idx;

    assign host_rdata = mem[idx];
    assign sq_rdata   = mem[sq_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (host_we)
                mem[idx] <= host_wdata;
            if (sq_we)
                mem[sq_addr] <= sq_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rewind)
            idx <= '0;
        else if (host_adv && idx != LAST)
            idx <= idx + 1'b1;
    end

    // R7
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (idx == '0));

    // R9
    idx_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!rewind && host_adv && idx == LAST) |=> (idx == LAST));

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int BW       = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          seq_start,
    output logic [2:0]    seq_proto,
    output logic [7:0]    seq_slave,
    output logic [7:0]    seq_cmd,
    output logic [7:0]    seq_data0,
    output logic [7:0]    seq_data1,
    input  logic          seq_done,
    input  logic          seq_nack,
    input  logic          seq_collision,
    input  logic          seq_failed,
    input  logic [7:0]    seq_rdata0,
    input  logic [7:0]    seq_rdata1,
    input  logic [BW-1:0] seq_buf_addr,
    input  logic          seq_buf_we,
    input  logic [7:0]    seq_buf_wdata,
    output logic [7:0]    seq_buf_rdata
);

    stat_t      st;
    ctl_t       ctl_q;
    logic [7:0] cmd_q, slv_q, d0_q, d1_q;
    logic       start_q;
    logic [7:0] blk_rdata;

    logic       wr_ok, start_go, rd_capture;
    logic [4:1] clr_mask;
    result_t    res_in;

    assign wr_ok      = reg_wr && !st.busy;
    assign start_go   = wr_ok && reg_addr == OFS_CTRL && reg_wdata[CTL_START_BIT];
    assign rd_capture = st.busy && seq_done && slv_q[0];
    assign clr_mask   = (reg_wr && reg_addr == OFS_STATUS) ? reg_wdata[4:1] : 4'b0;
    assign res_in     = '{failed: seq_failed, collision: seq_collision, nack: seq_nack};

    smbh_status u_status (
        .clk      (clk),
        .rst      (rst),
        .start_go (start_go),
        .clr_mask (clr_mask),
        .seq_done (seq_done),
        .seq_res  (res_in),
        .st       (st)
    );

    smbh_blkbuf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .rewind     (reg_rd && reg_addr == OFS_CTRL),
        .host_adv   (reg_addr == OFS_BLOCK && (reg_rd || wr_ok)),
        .host_we    (wr_ok && reg_addr == OFS_BLOCK),
        .host_wdata (reg_wdata),
        .host_rdata (blk_rdata),
        .sq_addr    (seq_buf_addr),
        .sq_we      (seq_buf_we),
        .sq_wdata   (seq_buf_wdata),
        .sq_rdata   (seq_buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            cmd_q   <= '0;
            slv_q   <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_go;
            if (wr_ok) begin
                unique case (reg_addr)
                    OFS_CTRL: begin
                        ctl_q.proto <= reg_wdata[4:2];
                        ctl_q.ien   <= reg_wdata[CTL_IEN_BIT];
                    end
                    OFS_CMD:   cmd_q <= reg_wdata;
                    OFS_SLAVE: slv_q <= reg_wdata;
                    OFS_DATA0: d0_q  <= reg_wdata;
                    OFS_DATA1: d1_q  <= reg_wdata;
                    default: ;
                endcase
            end
            if (rd_capture) begin
                d0_q <= seq_rdata0;
                d1_q <= seq_rdata1;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STATUS: reg_rdata = status_byte(st);
            OFS_CTRL:   reg_rdata = ctl_byte(ctl_q);
            OFS_CMD:    reg_rdata = cmd_q;
            OFS_SLAVE:  reg_rdata = slv_q;
            OFS_DATA0:  reg_rdata = d0_q;
            OFS_DATA1:  reg_rdata = d1_q;
            OFS_BLOCK:  reg_rdata = blk_rdata;
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign irq       = ctl_q.ien && st.done;
    assign seq_start = start_q;
    assign seq_proto = ctl_q.proto;
    assign seq_slave = slv_q;
    assign seq_cmd   = cmd_q;
    assign seq_data0 = d0_q;
    assign seq_data1 = d1_q;

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> st.busy);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> !seq_start);

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && st.busy && reg_addr == OFS_CMD) |=> $stable(cmd_q));

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        st.busy |=> !seq_start);

endmodule

// File: tb/sim_smbus_host_regs.sv
module sim_smbus_host_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq, seq_start;
    logic [2:0] seq_proto;
    logic [7:0] seq_slave, seq_cmd, seq_data0, seq_data1;
    logic       seq_done = 1'b0, seq_nack = 1'b0, seq_collision = 1'b0, seq_failed = 1'b0;
    logic [7:0] seq_rdata0 = '0, seq_rdata1 = '0;
    logic [4:0] seq_buf_addr = '0;
    logic       seq_buf_we = 1'b0;
    logic [7:0] seq_buf_wdata = '0, seq_buf_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    smbus_host_regs u0 (.*);

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    // monitor: compares every register read against the scoreboard
    always @(negedge clk) begin
        if (reg_rd) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: read got %02h expected nothing", reg_rdata);
            end else begin
                cur = sb.pop_front();
                if (reg_rdata !== cur.exp) begin
                    errors++;
                    $display("FAIL %s: read got %02h expected %02h", cur.tag, reg_rdata, cur.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb.push_back(e);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic finish_xfer(input logic n, input logic c, input logic f,
                               input logic [7:0] r0, input logic [7:0] r1);
        seq_nack = n; seq_collision = c; seq_failed = f;
        seq_rdata0 = r0; seq_rdata1 = r1; seq_done = 1'b1;
        @(posedge clk); #1;
        seq_done = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 seq_start", {7'b0, seq_start}, 8'h00);
        rd(3'd0, 8'h00, "R1 status");
        rd(3'd2, 8'h00, "R1 control");
        rd(3'd5, 8'h00, "R1 data0");

        // R2 plain registers
        wr(3'd3, 8'hA5); wr(3'd4, 8'h50); wr(3'd5, 8'h3C); wr(3'd6, 8'hC3);
        rd(3'd3, 8'hA5, "R2 command");
        rd(3'd4, 8'h50, "R2 slave");
        rd(3'd5, 8'h3C, "R2 data0");
        rd(3'd6, 8'hC3, "R2 data1");
        rd(3'd1, 8'h00, "R2 offset1");

        // R3 start word-data write, interrupt enabled
        wr(3'd2, 8'h4D);
        chk("R3 seq_start pulse", {7'b0, seq_start}, 8'h01);
        chk("R3 seq_proto", {5'b0, seq_proto}, 8'h03);
        chk("R3 seq_slave", seq_slave, 8'h50);
        chk("R3 seq_cmd", seq_cmd, 8'hA5);
        @(posedge clk); #1;
        chk("R3 seq_start single", {7'b0, seq_start}, 8'h00);
        rd(3'd0, 8'h01, "R3 busy");
        rd(3'd2, 8'h0D, "R3 control readback");

        // R6 writes ignored while busy
        wr(3'd3, 8'h11);
        rd(3'd3, 8'hA5, "R6 command held");
        wr(3'd2, 8'h40);
        chk("R6 no second start", {7'b0, seq_start}, 8'h00);
        rd(3'd2, 8'h0D, "R6 control held");

        // R4 completion with nack and failed
        finish_xfer(1'b1, 1'b0, 1'b1, 8'hEE, 8'hDD);
        rd(3'd0, 8'h16, "R4 status after done");
        chk("R10 irq high", {7'b0, irq}, 8'h01);
        rd(3'd5, 8'h3C, "R11 write direction data0 kept");

        // R5 write-one-to-clear
        wr(3'd0, 8'h04);
        rd(3'd0, 8'h12, "R5 clear nack only");
        wr(3'd0, 8'hE1);
        rd(3'd0, 8'h12, "R5 busy and high bits unaffected");
        wr(3'd0, 8'h12);
        rd(3'd0, 8'h00, "R5 clear all");
        chk("R10 irq low after clear", {7'b0, irq}, 8'h00);

        // R11 read direction, byte-data, interrupt disabled
        wr(3'd4, 8'hA1);
        wr(3'd2, 8'h48);
        chk("R3 seq_proto byte-data", {5'b0, seq_proto}, 8'h02);
        finish_xfer(1'b0, 1'b1, 1'b0, 8'h77, 8'h88);
        rd(3'd0, 8'h0A, "R4 collision flag");
        chk("R10 irq gated by enable", {7'b0, irq}, 8'h00);
        rd(3'd5, 8'h77, "R11 data0 captured");
        rd(3'd6, 8'h88, "R11 data1 captured");
        wr(3'd0, 8'h1E);
        wr(3'd4, 8'h50);

        // R8 / R12 block buffer basics
        rd(3'd2, 8'h08, "R7 control read rewinds");
        wr(3'd7, 8'h10); wr(3'd7, 8'h20); wr(3'd7, 8'h30);
        seq_buf_addr = 5'd0; #1 chk("R12 seq read byte0", seq_buf_rdata, 8'h10);
        seq_buf_addr = 5'd2; #1 chk("R12 seq read byte2", seq_buf_rdata, 8'h30);
        rd(3'd2, 8'h08, "R7 rewind");
        rd(3'd7, 8'h10, "R8 block byte0");
        rd(3'd7, 8'h20, "R8 block byte1");
        rd(3'd7, 8'h30, "R8 block byte2");
        rd(3'd2, 8'h08, "R7 rewind again");
        rd(3'd7, 8'h10, "R7 byte0 after rewind");

        // R9 saturation
        rd(3'd2, 8'h08, "R7 rewind before fill");
        for (int i = 0; i < 33; i++) wr(3'd7, 8'h40 + 8'(i));
        rd(3'd2, 8'h08, "R7 rewind after fill");
        for (int i = 0; i < 31; i++) rd(3'd7, 8'h40 + 8'(i), "R8 block sequential read");
        rd(3'd7, 8'h60, "R9 byte31 overwritten by saturated write");
        rd(3'd7, 8'h60, "R9 read past end stays at 31");
        seq_buf_addr = 5'd31; #1 chk("R9 seq view byte31", seq_buf_rdata, 8'h60);

        // R12 sequencer write seen by host
        seq_buf_addr = 5'd4; seq_buf_wdata = 8'hEE; seq_buf_we = 1'b1;
        @(posedge clk); #1 seq_buf_we = 1'b0;
        rd(3'd2, 8'h08, "R7 rewind");
        for (int i = 0; i < 4; i++) rd(3'd7, 8'h40 + 8'(i), "R12 untouched bytes");
        rd(3'd7, 8'hEE, "R12 host sees sequencer write");

        // R6 block write ignored while busy
        wr(3'd2, 8'h54);
        chk("R3 seq_proto block", {5'b0, seq_proto}, 8'h05);
        rd(3'd2, 8'h14, "R7 rewind while busy");
        wr(3'd7, 8'h99);
        rd(3'd7, 8'h40, "R6 block write ignored and index not moved");
        finish_xfer(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        rd(3'd0, 8'h02, "R4 clean completion");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule